// File: doc/BRIEF.md
# Quad-Output Serial Flash Read Responder

This block is the memory side of a serial NOR flash, reduced to one command: a read whose data comes back four bits per serial clock. A host pulls chip select low and shifts in an eight-bit opcode on IO0. The opcode is followed by a 24-bit start address and one dummy byte. All of these header bits arrive one per rising edge of the serial clock. The responder then places each stored byte on IO3..IO0 on successive falling edges, high nibble first. After each byte it steps its own address counter, and the counter folds back to zero past the top of the array.

The serial pins are oversampled by the block's system clock. A single register stage captures chip select, the serial clock and IO0, and edges are found by comparing that stage with the one before it. The four data lines leave as separate value and output-enable vectors, so that pad logic can build the tri-state drivers. A quad-enable configuration bit and a busy flag from an internal write or erase engine decide whether the command is accepted. The storage is a small synchronous array that a testbench or loader fills through a back-door write port.

Top module: `qor_responder`

## Requirements
- R1: Out of reset and whenever chip select is high, `io_oe` is 4'b0000 and `io_out` is 4'b0000.
- R2: During the 40 header bits (8 opcode, 24 address, 8 dummy), `io_oe` stays 4'b0000. The lines are first driven by the falling serial-clock edge that follows the 40th rising edge.
- R3: The opcode is taken MSB first and must equal the parameter `OPCODE` (default 8'h6B). Any other value leaves all four lines undriven until chip select goes high.
- R4: The address is taken MSB first (bit 23 first). Only its low log2(`DEPTH`) bits select the array entry, and `DEPTH` must be a power of two.
- R5: On each data-phase falling edge, `io_oe` becomes 4'b1111. The first edge of a byte drives bits [7:4] on IO3..IO0 and the second drives bits [3:0], so IO3 carries bit 7 then bit 3 and IO0 carries bit 4 then bit 0.
- R6: After both nibbles of a byte, the array index increments by one. From `DEPTH`-1 it returns to 0, and the read continues as long as clocks arrive.
- R7: If `cfg_quad_en` is 0 when the eighth opcode bit is taken, the command is ignored and the lines stay undriven until chip select rises.
- R8: If `busy` is 1 when the eighth opcode bit is taken, the command is ignored and the lines stay undriven until chip select rises.
- R9: Raising chip select at any point, including in mid-byte, releases all four lines by the second system clock edge after the pin changes. The next low period starts a fresh command.
- R10: Each pin change is seen by the logic one system clock after it happens, through a single sampling register. An output change caused by a serial-clock edge therefore appears on the second system clock edge after that pin edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| io0_in | input | 1 | IO0 input value (opcode, address and dummy bits) |
| cfg_quad_en | input | 1 | Quad-enable configuration bit |
| busy | input | 1 | An internal program, erase or register write is in progress |
| bd_we | input | 1 | Back-door write strobe for the array |
| bd_addr | input | AW | Back-door write index |
| bd_wdata | input | 8 | Back-door write byte |
| io_out | output | 4 | Values for IO3..IO0 |
| io_oe | output | 4 | Output enables for IO3..IO0 |

## Verification
Reads are issued from a low start address and from a start address whose upper bits are set and whose index sits two below the top of the array. The first read separates correct nibble order and pin mapping from swapped ones. The second shows that upper address bits are dropped and that the counter folds to zero. Commands with a wrong opcode, with quad enable cleared and with busy raised are each sent, and after each one an accepted read is sent. This separates a rejection that holds until chip select rises from one that leaks into the next transaction. A read cut off after one nibble checks that the lines are released at once.

// File: rtl/qor_pkg.sv
package qor_pkg;

  localparam int CMD_BITS   = 8;
  localparam int ADDR_BITS  = 24;
  localparam int DUMMY_BITS = 8;
  localparam int HDR_BITS   = CMD_BITS + ADDR_BITS + DUMMY_BITS;
  localparam int CNT_W      = $clog2(HDR_BITS);

  typedef enum logic [2:0] {
    ST_CMD   = 3'd0,
    ST_ADDR  = 3'd1,
    ST_DUMMY = 3'd2,
    ST_DATA  = 3'd3,
    ST_DROP  = 3'd4
  } qor_state_e;

  // Selects the nibble of a byte that goes out on IO3..IO0.
  function automatic logic [3:0] pick_nibble(input logic [7:0] b, input logic low_half);
    return low_half ? b[3:0] : b[7:4];
  endfunction

  // Decides whether a completed opcode starts a quad read.
  function automatic logic cmd_accepted(input logic [7:0] opc, input logic [7:0] want,
                                        input logic qe, input logic bsy);
    return (opc == want) && qe && !bsy;
  endfunction

endpackage

// File: rtl/qor_sampler.sv
module qor_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic io0_in,
  output logic cs_q,
  output logic d_q,
  output logic sck_rise,
  output logic sck_fall
);
  logic sck_q;
  logic sck_qq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      d_q    <= 1'b0;
      sck_q  <= 1'b0;
      sck_qq <= 1'b0;
    end else begin
      cs_q   <= cs_n;
      d_q    <= io0_in;
      sck_q  <= sck;
      sck_qq <= sck_q;
    end
  end

  assign sck_rise = sck_q & ~sck_qq;
  assign sck_fall = ~sck_q & sck_qq;

endmodule

// File: rtl/qor_seq.sv
module qor_seq
  import qor_pkg::*;
#(
  parameter logic [7:0] OPCODE = 8'h6B,
  parameter int         AW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_q,
  input  logic          d_q,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          quad_en,
  input  logic          busy,
  output qor_state_e    state,
  output logic [AW-1:0] ptr,
  output logic          data_fall,
  output logic          nib_low,
  output logic          cmd_done
);
  localparam int SW = (AW - 1 > CMD_BITS - 1) ? AW - 1 : CMD_BITS - 1;

  logic [SW-1:0]    shreg;
  logic [CNT_W-1:0] bitcnt;
  logic             hdr_rise;
  logic             addr_done;
  logic             dummy_done;
  logic [7:0]       cmd_byte;
  logic [AW-1:0]    addr_low;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return p + 1'b1;
  endfunction

  assign hdr_rise   = sck_rise && (state == ST_CMD || state == ST_ADDR || state == ST_DUMMY);
  assign cmd_done   = sck_rise && state == ST_CMD && bitcnt == CNT_W'(CMD_BITS - 1);
  assign addr_done  = sck_rise && state == ST_ADDR && bitcnt == CNT_W'(CMD_BITS + ADDR_BITS - 1);
  assign dummy_done = sck_rise && state == ST_DUMMY && bitcnt == CNT_W'(HDR_BITS - 1);
  assign data_fall  = sck_fall && state == ST_DATA;
  assign cmd_byte   = {shreg[CMD_BITS-2:0], d_q};
  assign addr_low   = {shreg[AW-2:0], d_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_CMD;
      bitcnt  <= '0;
      shreg   <= '0;
      ptr     <= '0;
      nib_low <= 1'b0;
    end else if (cs_q) begin
      state   <= ST_CMD;
      bitcnt  <= '0;
      nib_low <= 1'b0;
    end else begin
      if (hdr_rise) begin
        shreg  <= {shreg[SW-2:0], d_q};
        bitcnt <= bitcnt + 1'b1;
      end
      if (cmd_done) begin
        state <= cmd_accepted(cmd_byte, OPCODE, quad_en, busy) ? ST_ADDR : ST_DROP;
      end
      if (addr_done) begin
        ptr   <= addr_low;
        state <= ST_DUMMY;
      end
      if (dummy_done) begin
        state <= ST_DATA;
      end
      if (data_fall) begin
        nib_low <= ~nib_low;
        if (nib_low) ptr <= step_ptr(ptr);
      end
    end
  end

  // R7: a cleared quad-enable bit turns the command away
  p_reject_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && !cs_q && !quad_en) |=> state == ST_DROP);

  // R8: a busy engine turns the command away
  p_reject_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && !cs_q && busy) |=> state == ST_DROP);

  // R6: the index moves inside a read only after a completed byte
  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && $past(state) == ST_DATA && !$stable(ptr)) |-> $past(data_fall && nib_low));

  // R2: the header counter never passes the header length
  p_hdr_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_DATA) |-> bitcnt < CNT_W'(HDR_BITS));

endmodule

// File: rtl/qor_store.sv
module qor_store #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          bd_we,
  input  logic [AW-1:0] bd_addr,
  input  logic [7:0]    bd_wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_byte
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (bd_we) mem[bd_addr] <= bd_wdata;
    rd_byte <= mem[rd_addr];
  end

endmodule

// File: rtl/qor_drive.sv
module qor_drive
  import qor_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_q,
  input  logic       data_fall,
  input  logic       nib_low,
  input  logic [7:0] rd_byte,
  output logic [3:0] io_out,
  output logic [3:0] io_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_out <= 4'h0;
      io_oe  <= 4'h0;
    end else if (cs_q) begin
      io_out <= 4'h0;
      io_oe  <= 4'h0;
    end else if (data_fall) begin
      io_out <= pick_nibble(rd_byte, nib_low);
      io_oe  <= 4'hF;
    end
  end

  // R5: every data-phase fall leaves all four lines driven
  p_drive_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fall && !cs_q) |=> io_oe == 4'hF);

endmodule

// File: rtl/qor_responder.sv
module qor_responder
  import qor_pkg::*;
#(
  parameter logic [7:0] OPCODE = 8'h6B,
  parameter int         DEPTH  = 256,
  localparam int        AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          io0_in,
  input  logic          cfg_quad_en,
  input  logic          busy,
  input  logic          bd_we,
  input  logic [AW-1:0] bd_addr,
  input  logic [7:0]    bd_wdata,
  output logic [3:0]    io_out,
  output logic [3:0]    io_oe
);
  logic          cs_q;
  logic          d_q;
  logic          sck_rise;
  logic          sck_fall;
  qor_state_e    state;
  logic [AW-1:0] ptr;
  logic          data_fall;
  logic          nib_low;
  logic          cmd_done;
  logic [7:0]    rd_byte;

  qor_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .io0_in(io0_in),
    .cs_q(cs_q), .d_q(d_q), .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  qor_seq #(.OPCODE(OPCODE), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .d_q(d_q),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .quad_en(cfg_quad_en), .busy(busy),
    .state(state), .ptr(ptr), .data_fall(data_fall),
    .nib_low(nib_low), .cmd_done(cmd_done)
  );

  qor_store #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .bd_we(bd_we), .bd_addr(bd_addr), .bd_wdata(bd_wdata),
    .rd_addr(ptr), .rd_byte(rd_byte)
  );

  qor_drive u_drv (
    .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .data_fall(data_fall),
    .nib_low(nib_low), .rd_byte(rd_byte), .io_out(io_out), .io_oe(io_oe)
  );

  // R9: a sampled high chip select releases the lines on the next edge
  p_cs_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |=> io_oe == 4'h0);

  // R2: driving starts only after a data-phase falling edge
  p_first_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_oe[0]) |-> $past(data_fall));

  // R3: a turned-away command keeps the lines quiet
  p_drop_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DROP) |-> io_oe == 4'h0);

endmodule

// File: tb/sim_qor_responder.sv
`timescale 1ns/1ps
module sim_qor_responder;
  localparam logic [7:0] OPC   = 8'h6B;
  localparam int         DEPTH = 256;
  localparam int         AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, io0 = 1'b0;
  logic qe = 1'b1, busy = 1'b0;
  logic bd_we = 1'b0;
  logic [AW-1:0] bd_addr = '0;
  logic [7:0] bd_wdata = '0;
  logic [3:0] io_out, io_oe;

  int n_checks = 0, n_fail = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;
  logic [7:0] ref_mem [DEPTH];

  always #2.5 clk = ~clk;

  qor_responder #(.OPCODE(OPC), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .io0_in(io0),
    .cfg_quad_en(qe), .busy(busy), .bd_we(bd_we), .bd_addr(bd_addr),
    .bd_wdata(bd_wdata), .io_out(io_out), .io_oe(io_oe)
  );

  // Behavioural reference: pin-level edge model, one clock of delay
  logic m_psck;
  int m_cnt, m_st, m_ph, m_addr;
  logic [31:0] m_sr;
  logic [3:0] exp_oe = 4'h0, exp_out = 4'h0, exp_oe_d = 4'h0, exp_out_d = 4'h0;

  always @(posedge clk) begin
    exp_oe_d  <= exp_oe;
    exp_out_d <= exp_out;
    if (!rst_n || cs_n) begin
      m_cnt = 0; m_st = 0; m_ph = 0; exp_oe = 4'h0; exp_out = 4'h0;
      if (!rst_n) m_addr = 0;
    end else if (sck && !m_psck && m_st == 0) begin
      m_sr = {m_sr[30:0], io0};
      m_cnt++;
      if (m_cnt == 8 && (m_sr[7:0] != OPC || !qe || busy)) m_st = 2;
      else if (m_cnt == 32) m_addr = int'(m_sr[23:0]) % DEPTH;
      else if (m_cnt == 40) m_st = 1;
    end else if (!sck && m_psck && m_st == 1) begin
      exp_oe  = 4'hF;
      exp_out = (m_ph == 1) ? ref_mem[m_addr][3:0] : ref_mem[m_addr][7:4];
      if (m_ph == 1) m_addr = (m_addr + 1) % DEPTH;
      m_ph = 1 - m_ph;
    end
    m_psck = sck;
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      n_checks++;
      if (io_oe !== exp_oe_d || (exp_oe_d != 4'h0 && io_out !== exp_out_d)) begin
        n_fail++;
        $display("FAIL %s/R10 per-clock: actual oe=%h out=%h expected oe=%h out=%h",
                 cur_req, io_oe, io_out, exp_oe_d, exp_out_d);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    io0 = b;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic data_clk(output logic [3:0] nib, output logic [3:0] oe);
    repeat (4) @(negedge clk);
    nib = io_out;
    oe  = io_oe;
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic end_cs(input string req);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(io_oe == 4'h0, req, "lines released after CS high", io_oe, 0);
    repeat (4) @(negedge clk);
  endtask

  // Header, then nbytes of data; expect_data selects accepted/ignored
  task automatic do_read(input logic [7:0] opc, input logic [23:0] a, input int nbytes,
                         input bit expect_data, input string req);
    logic [3:0] hi, lo, oh, ol;
    logic [39:0] hdr;
    cur_req = req;
    hdr = {opc, a, 8'h00};
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 39; i >= 0; i--) begin
      if (i == 0) chk(io_oe == 4'h0, "R2", "undriven before last dummy bit", io_oe, 0);
      send_bit(hdr[i]);
    end
    for (int b = 0; b < nbytes; b++) begin
      int idx;
      idx = ((int'(a) % DEPTH) + b) % DEPTH;
      data_clk(hi, oh);
      data_clk(lo, ol);
      if (expect_data) begin
        chk(oh == 4'hF && ol == 4'hF, "R5", "all lines driven in data phase", {oh, ol}, 8'hFF);
        chk({hi, lo} == ref_mem[idx], req, $sformatf("byte %0d (index %0h)", b, idx),
            {hi, lo}, ref_mem[idx]);
      end else begin
        chk(oh == 4'h0 && ol == 4'h0, req, "ignored command leaves lines undriven", {oh, ol}, 0);
      end
    end
    end_cs(req);
  endtask

  initial begin
    logic [3:0] hn, ho;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(io_oe == 4'h0 && io_out == 4'h0, "R1", "reset state", {io_oe, io_out}, 0);
    for (int i = 0; i < DEPTH; i++) begin
      bd_we = 1'b1; bd_addr = AW'(i); bd_wdata = ref_mem[i];
      @(negedge clk);
    end
    bd_we = 1'b0;
    repeat (2) @(negedge clk);
    cmp_on = 1'b1;

    // R3/R4/R5: plain read, nibble order and MSB-first header
    do_read(OPC, 24'h000010, 6, 1'b1, "R5");
    // R4/R6: high address bits dropped; index wraps from top to zero
    do_read(OPC, 24'hABCDFE, 5, 1'b1, "R6");
    // R3: wrong opcode ignored, then a normal read still works
    do_read(8'h0B, 24'h000020, 2, 1'b0, "R3");
    do_read(OPC, 24'h000021, 2, 1'b1, "R3");
    // R7: quad enable cleared
    qe = 1'b0;
    do_read(OPC, 24'h000030, 2, 1'b0, "R7");
    qe = 1'b1;
    do_read(OPC, 24'h000030, 2, 1'b1, "R7");
    // R8: busy engine
    busy = 1'b1;
    do_read(OPC, 24'h000040, 2, 1'b0, "R8");
    busy = 1'b0;
    do_read(OPC, 24'h7FFF80, 3, 1'b1, "R4");
    // R9: CS raised after the high nibble
    cur_req = "R9";
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 39; i >= 0; i--) send_bit(i >= 32 ? OPC[i - 32] : (i >= 8 ? 1'b0 : 1'b0));
    data_clk(hn, ho);
    chk(ho == 4'hF && hn == ref_mem[0][7:4], "R9", "high nibble before cut", {ho, hn}, {4'hF, ref_mem[0][7:4]});
    end_cs("R9");
    do_read(OPC, 24'h000005, 2, 1'b1, "R9");

    cmp_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog %s: actual timeout expected completion", cur_req);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule